// File: doc/BRIEF.md
# Context-Indexed Probability Adapter

This block keeps the adaptive probability state of an arithmetic coder. For every context it stores a probability index and the value of the more probable symbol (MPS). On each coding step it hands the coder an interval size (Qe) and the expected symbol. It then adapts the stored state from the outcome of that step: an MPS event or a less-probable-symbol (LPS) event.

A request presents a context word address. Each addressed word holds two state pairs, one for each value of a bit that is only known late in the step. Both pairs are read together and converted to Qe in parallel. A late select input picks one of them in the cycle the result is used. The state store has one read port and one write port. A fresh update waits in a pending register until it is written, and that register is forwarded to any read of the same word in the meantime.

A mode input chooses between two table sets. When set, it also restricts the block to the lowest 64 words.

Top module: `ctx_prob_adapter`

## Requirements
- R1: After reset, `out_valid` is 0. Every state pair holds index 0 with MPS 0, so the first lookup of any context returns the index-0 Qe and MPS 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1. In that cycle `out_qe` and `out_mps` follow the `late_sel` driven in that same cycle, and `lps_event` is sampled in that same cycle.
- R3: Each word holds two pairs. Bits [7:0] are selected by `late_sel` = 0 and bits [15:8] by `late_sel` = 1. Within a pair, bit 7 is the MPS and bits [6:0] are the index. A step updates only the selected pair.
- R4: Qe is `16'h5800 >> idx` when `legacy_mode` = 0 and `16'h4000 >> idx` when `legacy_mode` = 1. There are 12 states, index 0 to 11.
- R5: After an MPS event, the index becomes min(idx+1, 11) with `legacy_mode` = 0, or min(idx+2, 11) with `legacy_mode` = 1. The MPS is unchanged.
- R6: After an LPS event, the index becomes max(idx-1, 0) with `legacy_mode` = 0, or max(idx-2, 0) with `legacy_mode` = 1. The MPS inverts only if the index before the event was 0.
- R7: A step sees every earlier update to its word. This holds when it follows the update in the very next cycle, after one idle cycle, and after two or more idle cycles.
- R8: With `legacy_mode` = 1, only `req_ctx[5:0]` addresses the store, and bits [8:6] are ignored.
- R9: Updates to one word leave the state of every other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all state |
| legacy_mode | input | 1 | Selects table set 1 and the 64-word address range |
| req_valid | input | 1 | A lookup is requested this cycle |
| req_ctx | input | 9 | Context word address |
| late_sel | input | 1 | Late bit choosing one of the two pairs of the word in the result cycle |
| lps_event | input | 1 | The current step coded an LPS (1) or an MPS (0) |
| out_valid | output | 1 | Result of last cycle's request is present |
| out_qe | output | 16 | Interval size for the selected pair |
| out_mps | output | 1 | Expected symbol for the selected pair |

## Verification
A request's result is due one clock edge later, in the result cycle. In that cycle the bench drives the late select and the outcome, then samples Qe and MPS combinationally 2 ns after the falling edge. Each update lands in the pending register at the next edge. It is visible to a request issued in the result cycle itself, which reaches its own result cycle one edge later. The driver models that order step by step and queues the expected Qe and MPS. The monitor pops one entry for every result-cycle `out_valid`. Back-to-back, one-gap and two-gap re-reads of one word cover both the forwarding path and the write-through read path.

// File: rtl/adapt_pkg.sv
// Shared widths and the state-pair type of the probability adapter.
// Assumes a pair fits in one byte: MPS in the top bit, index below.
package adapt_pkg;
    localparam int IDX_W  = 7;
    localparam int PAIR_W = IDX_W + 1;
    localparam int QE_W   = 16;

    typedef struct packed {
        logic             mps;
        logic [IDX_W-1:0] idx;
    } pstate_t;
endpackage

// File: rtl/adapt_state_mem.sv
// State store: one synchronous read port and one write port.
// Assumes a write and a read of the same word in one cycle return the new data.
// Reset clears every word to zero over a single cycle.
module adapt_state_mem #(
    parameter int AW    = 9,
    parameter int DW    = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] store [DEPTH];

    // Write port: clear on reset, else commit the pending word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Read port: registered, passing through a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (wr_en && (wr_addr == rd_addr))
            rd_data <= wr_data;
        else
            rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/adapt_qconv.sv
// Converts a probability index to an interval size for one table set.
// Assumes indices at or above NSTATE behave as the last state.
module adapt_qconv
    import adapt_pkg::*;
#(
    parameter int              NSTATE = 12,
    parameter logic [QE_W-1:0] BASE0  = 16'h5800,
    parameter logic [QE_W-1:0] BASE1  = 16'h4000
) (
    input  logic             tbl_sel,
    input  logic [IDX_W-1:0] idx,
    output logic [QE_W-1:0]  qe
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NSTATE - 1);

    // Clamp the index and shift the selected base value down.
    always_comb begin
        logic [IDX_W-1:0] ic;
        ic = (idx > TOP) ? TOP : idx;
        qe = (tbl_sel ? BASE1 : BASE0) >> ic;
    end
endmodule

// File: rtl/adapt_next.sv
// Next-state rule for one pair: move up after an MPS event, down after
// an LPS event, and flip the MPS on an LPS event at the bottom state.
// Assumes the step sizes are below NSTATE.
module adapt_next
    import adapt_pkg::*;
#(
    parameter int NSTATE = 12,
    parameter int STEP0  = 1,
    parameter int STEP1  = 2
) (
    input  logic    tbl_sel,
    input  pstate_t cur,
    input  logic    lps,
    output pstate_t nxt
);
    localparam logic [IDX_W:0]   TOP_W = (IDX_W+1)'(NSTATE - 1);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(NSTATE - 1);

    // Compute both candidate indices and pick one by outcome.
    always_comb begin
        logic [IDX_W:0] step;
        logic [IDX_W:0] up;
        logic [IDX_W:0] wide;
        step = tbl_sel ? (IDX_W+1)'(STEP1) : (IDX_W+1)'(STEP0);
        wide = {1'b0, cur.idx};
        up   = wide + step;
        nxt.mps = cur.mps ^ (lps && (cur.idx == '0));
        if (lps)
            nxt.idx = (wide >= step) ? IDX_W'(wide - step) : '0;
        else
            nxt.idx = (up > TOP_W) ? TOP : IDX_W'(up);
    end
endmodule

// File: rtl/ctx_prob_adapter.sv
// Context-indexed probability adapter. A request reads a two-pair word.
// In the next cycle both pairs are converted and the late select picks
// one, and the coding outcome updates that pair into a pending register.
// The pending register is written to the store one cycle later and
// forwarded to reads of the same word until then.
// Assumes legacy_mode changes only while no step is in flight.
module ctx_prob_adapter
    import adapt_pkg::*;
#(
    parameter int CTX_W   = 9,
    parameter int LEG_W   = 6,
    parameter int NSTATE  = 12,
    parameter int NHALF   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy_mode,
    input  logic             req_valid,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             late_sel,
    input  logic             lps_event,
    output logic             out_valid,
    output logic [QE_W-1:0]  out_qe,
    output logic             out_mps
);
    localparam int DW = NHALF * PAIR_W;

    logic [CTX_W-1:0] rd_addr;
    logic [DW-1:0]    mem_q;
    logic             s1_v;
    logic [CTX_W-1:0] s1_addr;
    logic             pend_v;
    logic [CTX_W-1:0] pend_addr;
    logic [DW-1:0]    pend_word;
    logic [DW-1:0]    cur_word;
    logic [DW-1:0]    new_word;
    pstate_t          pair_h [NHALF];
    pstate_t          nxt_h  [NHALF];
    logic [QE_W-1:0]  qe_h   [NHALF];

    // Restrict the address to the low words in legacy mode.
    always_comb begin
        rd_addr = req_ctx;
        if (legacy_mode) rd_addr[CTX_W-1:LEG_W] = '0;
    end

    adapt_state_mem #(.AW(CTX_W), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (mem_q),
        .wr_en   (pend_v),
        .wr_addr (pend_addr),
        .wr_data (pend_word)
    );

    // Track which word is in the result stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_v    <= req_valid;
            s1_addr <= rd_addr;
        end
    end

    // Forward the not-yet-written update when it targets this word.
    always_comb begin
        cur_word = (pend_v && (pend_addr == s1_addr)) ? pend_word : mem_q;
    end

    // Per half: unpack, convert and compute the successor in parallel.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign pair_h[h] = cur_word[h*PAIR_W +: PAIR_W];

        adapt_qconv #(.NSTATE(NSTATE)) u_qconv (
            .tbl_sel (legacy_mode),
            .idx     (pair_h[h].idx),
            .qe      (qe_h[h])
        );

        adapt_next #(.NSTATE(NSTATE)) u_next (
            .tbl_sel (legacy_mode),
            .cur     (pair_h[h]),
            .lps     (lps_event),
            .nxt     (nxt_h[h])
        );

        assign new_word[h*PAIR_W +: PAIR_W] =
            (late_sel == h[0]) ? nxt_h[h] : pair_h[h];
    end

    // Late select of the coder-facing result.
    always_comb begin
        out_valid = s1_v;
        out_qe    = qe_h[late_sel];
        out_mps   = pair_h[late_sel].mps;
    end

    // Capture the updated word into the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_word <= '0;
        end else begin
            pend_v <= s1_v;
            if (s1_v) begin
                pend_addr <= s1_addr;
                pend_word <= new_word;
            end
        end
    end
endmodule

// File: rtl/ctx_prob_adapter_chk.sv
// Port-level properties of the probability adapter, bound to the top.
module ctx_prob_adapter_chk
    import adapt_pkg::*;
#(
    parameter int CTX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             legacy_mode,
    input logic             req_valid,
    input logic [CTX_W-1:0] req_ctx,
    input logic             late_sel,
    input logic             lps_event,
    input logic             out_valid,
    input logic [QE_W-1:0]  out_qe,
    input logic             out_mps
);
    // R2
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    no_result_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R4
    qe_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_qe != '0));

    // R5
    mps_step_keeps_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && ($past(req_ctx, 2) == $past(req_ctx))
         && ($past(late_sel) == late_sel) && !$past(lps_event)
         && $stable(legacy_mode) && $past($stable(legacy_mode)))
        |-> (out_mps == $past(out_mps)));

    // R5
    mps_step_shrinks_qe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && ($past(req_ctx, 2) == $past(req_ctx))
         && ($past(late_sel) == late_sel) && !$past(lps_event)
         && $stable(legacy_mode) && $past($stable(legacy_mode)))
        |-> (out_qe <= $past(out_qe)));
endmodule

bind ctx_prob_adapter ctx_prob_adapter_chk #(.CTX_W(CTX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .req_valid   (req_valid),
    .req_ctx     (req_ctx),
    .late_sel    (late_sel),
    .lps_event   (lps_event),
    .out_valid   (out_valid),
    .out_qe      (out_qe),
    .out_mps     (out_mps)
);

// File: tb/ctx_prob_adapter_test.sv
// Scoreboard bench: the driver models the expected result of every step
// and queues it; the monitor pops one entry per result cycle.
module ctx_prob_adapter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [8:0]  req_ctx = '0;
    logic        late_sel = 1'b0;
    logic        lps_event = 1'b0;
    logic        out_valid;
    logic [15:0] out_qe;
    logic        out_mps;

    int total = 0;
    int bad   = 0;

    logic [15:0] model [512];
    logic [15:0] exp_qe_q [$];
    logic        exp_mps_q [$];
    string       tag_q [$];
    logic        pend_sel = 1'b0;
    logic        pend_lps = 1'b0;

    always #10 clk = ~clk;

    ctx_prob_adapter uut (
        .clk (clk), .rst_n (rst_n), .legacy_mode (legacy_mode),
        .req_valid (req_valid), .req_ctx (req_ctx), .late_sel (late_sel),
        .lps_event (lps_event), .out_valid (out_valid), .out_qe (out_qe),
        .out_mps (out_mps)
    );

    // Driver step: model expected output, update the model, drive the request.
    task automatic step(input int ctx, input bit sel, input bit lps, input string tag);
        int         a;
        logic [7:0] pr;
        int         idx;
        logic       m;
        int         nidx;
        int         stp;
        a   = legacy_mode ? (ctx & 63) : ctx;
        pr  = sel ? model[a][15:8] : model[a][7:0];
        idx = int'(pr[6:0]);
        m   = pr[7];
        exp_qe_q.push_back((legacy_mode ? 16'h4000 : 16'h5800) >> idx);
        exp_mps_q.push_back(m);
        tag_q.push_back(tag);
        stp = legacy_mode ? 2 : 1;
        if (lps) begin
            nidx = (idx >= stp) ? idx - stp : 0;
            if (idx == 0) m = ~m;
        end else begin
            nidx = (idx + stp > 11) ? 11 : idx + stp;
        end
        pr = {m, 7'(nidx)};
        if (sel) model[a][15:8] = pr; else model[a][7:0] = pr;
        @(negedge clk);
        req_valid = 1'b1;
        req_ctx   = 9'(ctx);
        late_sel  = pend_sel;
        lps_event = pend_lps;
        pend_sel  = sel;
        pend_lps  = lps;
    endtask

    // Driver idle cycles: finish the previous step's late inputs.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            late_sel  = pend_sel;
            lps_event = pend_lps;
            pend_sel  = 1'b0;
            pend_lps  = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: compare each result-cycle output with the queued expectation.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            if (exp_qe_q.size() == 0) begin
                check(1'b0, $sformatf("R2 unexpected result qe=%h expected none", out_qe));
            end else begin
                logic [15:0] eq;
                logic        em;
                string       t;
                eq = exp_qe_q.pop_front();
                em = exp_mps_q.pop_front();
                t  = tag_q.pop_front();
                check((out_qe === eq) && (out_mps === em),
                      $sformatf("%s qe=%h mps=%b expected qe=%h mps=%b",
                                t, out_qe, out_mps, eq, em));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #(20 * 150000);
        check(1'b0, "R2 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        #2;
        check(out_valid === 1'b0, $sformatf("R1 out_valid=%b expected 0", out_valid));

        // R1 reset state, R5 climb to saturation back to back (R7 forward path)
        for (int i = 0; i < 14; i++) step(3, 1'b0, 1'b0, "R5/R7 climb ctx3 lo");
        // R3 other half untouched
        step(3, 1'b1, 1'b0, "R3 ctx3 hi untouched");
        step(3, 1'b0, 1'b0, "R3 ctx3 lo kept");
        idle(1);
        // R6 LPS at bottom flips MPS
        step(10, 1'b0, 1'b1, "R1/R6 ctx10 first lookup");
        step(10, 1'b0, 1'b0, "R6 ctx10 flipped mps");
        // R6 LPS above bottom keeps MPS
        step(20, 1'b1, 1'b0, "R6 ctx20 up");
        step(20, 1'b1, 1'b0, "R6 ctx20 up");
        step(20, 1'b1, 1'b0, "R6 ctx20 up");
        step(20, 1'b1, 1'b1, "R6 ctx20 lps at idx3");
        step(20, 1'b1, 1'b1, "R6 ctx20 after lps");
        step(20, 1'b1, 1'b1, "R6 ctx20 down");
        step(20, 1'b1, 1'b0, "R6 ctx20 bottom flip");
        // R7 one and two idle gaps
        step(40, 1'b0, 1'b0, "R7 ctx40 a");
        idle(1);
        step(40, 1'b0, 1'b0, "R7 ctx40 gap1");
        idle(2);
        step(40, 1'b0, 1'b1, "R7 ctx40 gap2");
        idle(3);
        step(40, 1'b0, 1'b0, "R7 ctx40 gap3");
        // R9 interleaved words
        for (int i = 0; i < 4; i++) begin
            step(100, 1'b0, 1'b0, "R9 ctx100");
            step(101, 1'b0, i[0], "R9 ctx101");
        end
        step(300, 1'b1, 1'b0, "R9 ctx300 fresh");
        idle(3);

        // Legacy mode: set 1 tables (R4), aliasing (R8)
        legacy_mode = 1'b1;
        idle(2);
        step(9'h45, 1'b0, 1'b0, "R4/R8 legacy ctx45");
        step(9'h05, 1'b0, 1'b0, "R8 alias ctx05");
        step(9'h185, 1'b0, 1'b0, "R5/R8 alias ctx185");
        for (int i = 0; i < 4; i++) step(5, 1'b0, 1'b0, "R5 legacy climb");
        step(5, 1'b0, 1'b1, "R5 legacy top");
        step(5, 1'b0, 1'b1, "R6 legacy down");
        step(3, 1'b0, 1'b0, "R4 legacy ctx3 saturated");
        step(3, 1'b0, 1'b1, "R4 ctx3");
        step(3, 1'b0, 1'b0, "R6 legacy ctx3 down");
        idle(3);
        legacy_mode = 1'b0;
        idle(2);
        step(9'h185, 1'b0, 1'b0, "R8 ctx185 untouched");
        idle(3);

        check(exp_qe_q.size() == 0,
              $sformatf("R2 pending results=%0d expected 0", exp_qe_q.size()));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule